// File: doc/BRIEF.md
# Tagged Store Buffer

This block keeps a short queue of pending memory writes. Each write arrives with the pieces of its target address, a base and a signed offset, and with its data. Either piece may still be in flight. In that case the write carries, in place of the value, the nonzero tag of the unit that will produce it. The buffer watches the shared result broadcast bus. When a broadcast tag matches a tag it is waiting on, it captures the value.

An entry forms its effective address once the base is known. The oldest entry is then offered to a single write port with a valid/ready handshake, but only when its address is formed and its data is present. Writes leave strictly in the order they arrived, one per accepted handshake. The allocating side is told through a full flag when no entry is free.

Top module: `tagged_store_buffer`

## Requirements
- R1: `full_o` is high exactly when DEPTH entries are held. An allocation presented while `full_o` is high stores nothing, so only the DEPTH earlier writes ever reach the port.
- R2: The effective address is the base plus the offset sign-extended from OFF_W bits, modulo 2^ADDR_W. It becomes valid on the clock edge after the base is known.
- R3: A base tag of zero means the base is given. A nonzero base tag holds the entry back until a broadcast with that tag arrives. The base is then taken from the low ADDR_W bits of the broadcast data.
- R4: A data tag of zero means the data is given. A nonzero data tag holds the entry back until a broadcast with that tag arrives, and the data is then taken from it. Broadcasts with other tags, or with `cdb_valid_i` low, change nothing.
- R5: A broadcast whose tag matches the tag of an allocation in the same cycle supplies that value to the new entry.
- R6: `mem_valid_o` is high only when the oldest held entry has a formed address and present data. A younger complete entry never goes first.
- R7: While `mem_valid_o` is high and `mem_ready_i` is low, the request and its address and data stay unchanged. On the accepting cycle the entry is freed, and the next oldest entry is offered afterwards.
- R8: After reset the buffer is empty: `mem_valid_o` and `full_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| alloc_valid_i | input | 1 | Allocate a new store this cycle |
| alloc_base_tag_i | input | TAG_W | Producer tag of the base, 0 when the base is given |
| alloc_base_i | input | ADDR_W | Base value, used when its tag is 0 |
| alloc_off_i | input | OFF_W | Signed address offset |
| alloc_data_tag_i | input | TAG_W | Producer tag of the data, 0 when the data is given |
| alloc_data_i | input | DATA_W | Data value, used when its tag is 0 |
| full_o | output | 1 | No free entry |
| cdb_valid_i | input | 1 | Broadcast bus carries a result |
| cdb_tag_i | input | TAG_W | Tag of the broadcasting producer |
| cdb_data_i | input | DATA_W | Broadcast result value |
| mem_valid_o | output | 1 | Write request to memory |
| mem_addr_o | output | ADDR_W | Write address |
| mem_data_o | output | DATA_W | Write data |
| mem_ready_i | input | 1 | Memory accepts the write |

## Verification
The assertions assume that no producer tag is broadcast twice while an entry is still waiting on it. They also assume that tag zero is never broadcast as a valid result, and that the allocating side respects `full_o` except in the one deliberate overflow probe. The stimulus gives every pending value its own fresh tag, drives broadcasts only with nonzero tags, and ties each allocation to a single cycle. Only the full-buffer case drives an allocation into `full_o` on purpose.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    AS_BASE_PEND = 2'd0,
    AS_CALC      = 2'd1,
    AS_DONE      = 2'd2
  } addr_state_e;
endpackage

// File: rtl/sb_agen.sv
module sb_agen #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16
) (
  input  logic [ADDR_W-1:0] base_i,
  input  logic [OFF_W-1:0]  off_i,
  output logic [ADDR_W-1:0] ea_o
);
  localparam int EXT_W = ADDR_W - OFF_W;
  logic [ADDR_W-1:0] off_ext;
  assign off_ext = {{EXT_W{off_i[OFF_W-1]}}, off_i};
  assign ea_o    = base_i + off_ext;
endmodule

// File: rtl/sb_ctrl.sv
module sb_ctrl #(
  parameter int DEPTH = 4,
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             alloc_valid_i,
  input  logic             pop_i,
  output logic             push_o,
  output logic [PTR_W-1:0] head_o,
  output logic [PTR_W-1:0] tail_o,
  output logic             full_o,
  output logic             empty_o
);
  logic [PTR_W-1:0] head_q, tail_q;
  logic [CNT_W-1:0] count_q;

  assign full_o  = (count_q == CNT_W'(DEPTH));
  assign empty_o = (count_q == '0);
  assign push_o  = alloc_valid_i && !full_o;
  assign head_o  = head_q;
  assign tail_o  = tail_q;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q  <= '0;
      tail_q  <= '0;
      count_q <= '0;
    end else begin
      if (push_o) tail_q <= nxt(tail_q);
      if (pop_i)  head_q <= nxt(head_q);
      case ({push_o, pop_i})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (alloc_valid_i && full_o && !pop_i) |=> full_o); // R1
  AST_NO_UNDERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> !pop_i); // R6
endmodule

// File: rtl/sb_entry.sv
module sb_entry
  import sb_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_i,
  input  logic [TAG_W-1:0]  alloc_base_tag_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  input  logic [OFF_W-1:0]  alloc_off_i,
  input  logic [TAG_W-1:0]  alloc_data_tag_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  input  logic              free_i,
  output logic              valid_o,
  output logic              ready_o,
  output logic [ADDR_W-1:0] addr_o,
  output logic [DATA_W-1:0] data_o
);
  logic              valid_q;
  addr_state_e       st_q;
  logic [TAG_W-1:0]  base_tag_q, data_tag_q;
  logic [ADDR_W-1:0] base_q, addr_q, ea;
  logic [OFF_W-1:0]  off_q;
  logic [DATA_W-1:0] data_q;
  logic              base_hit, data_hit, new_base_hit, new_data_hit;

  sb_agen #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_agen (
    .base_i(base_q), .off_i(off_q), .ea_o(ea)
  );

  assign base_hit     = cdb_valid_i && (base_tag_q != '0) && (cdb_tag_i == base_tag_q);
  assign data_hit     = cdb_valid_i && (data_tag_q != '0) && (cdb_tag_i == data_tag_q);
  assign new_base_hit = cdb_valid_i && (alloc_base_tag_i != '0) && (cdb_tag_i == alloc_base_tag_i);
  assign new_data_hit = cdb_valid_i && (alloc_data_tag_i != '0) && (cdb_tag_i == alloc_data_tag_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q    <= 1'b0;
      st_q       <= AS_BASE_PEND;
      base_tag_q <= '0;
      data_tag_q <= '0;
      base_q     <= '0;
      addr_q     <= '0;
      off_q      <= '0;
      data_q     <= '0;
    end else if (alloc_i) begin
      valid_q <= 1'b1;
      off_q   <= alloc_off_i;
      if (alloc_base_tag_i == '0) begin
        base_q <= alloc_base_i;  base_tag_q <= '0; st_q <= AS_CALC;
      end else if (new_base_hit) begin
        base_q <= cdb_data_i[ADDR_W-1:0]; base_tag_q <= '0; st_q <= AS_CALC;
      end else begin
        base_q <= alloc_base_i;  base_tag_q <= alloc_base_tag_i; st_q <= AS_BASE_PEND;
      end
      if (alloc_data_tag_i == '0) begin
        data_q <= alloc_data_i;  data_tag_q <= '0;
      end else if (new_data_hit) begin
        data_q <= cdb_data_i;    data_tag_q <= '0;
      end else begin
        data_q <= alloc_data_i;  data_tag_q <= alloc_data_tag_i;
      end
    end else if (free_i) begin
      valid_q <= 1'b0;
    end else if (valid_q) begin
      case (st_q)
        AS_BASE_PEND: if (base_hit) begin
          base_q     <= cdb_data_i[ADDR_W-1:0];
          base_tag_q <= '0;
          st_q       <= AS_CALC;
        end
        AS_CALC: begin
          addr_q <= ea;
          st_q   <= AS_DONE;
        end
        default: ;
      endcase
      if (data_hit) begin
        data_q     <= cdb_data_i;
        data_tag_q <= '0;
      end
    end
  end

  assign valid_o = valid_q;
  assign ready_o = valid_q && (st_q == AS_DONE) && (data_tag_q == '0);
  assign addr_o  = addr_q;
  assign data_o  = data_q;

  AST_AGEN_NEXT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && st_q == AS_CALC && !free_i && !alloc_i) |=> (st_q == AS_DONE && addr_q == $past(ea))); // R2
  AST_BASE_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && st_q == AS_BASE_PEND && base_hit && !free_i && !alloc_i)
      |=> (st_q == AS_CALC && base_q == $past(cdb_data_i[ADDR_W-1:0]))); // R3
  AST_DATA_SNOOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && data_hit && !free_i && !alloc_i) |=> (data_tag_q == '0 && data_q == $past(cdb_data_i))); // R4
  AST_DATA_WAIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_q && data_tag_q != '0 && !data_hit && !free_i && !alloc_i) |=> $stable(data_tag_q)); // R4
endmodule

// File: rtl/tagged_store_buffer.sv
module tagged_store_buffer #(
  parameter int DEPTH  = 4,
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 16,
  parameter int DATA_W = 64,
  parameter int TAG_W  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              alloc_valid_i,
  input  logic [TAG_W-1:0]  alloc_base_tag_i,
  input  logic [ADDR_W-1:0] alloc_base_i,
  input  logic [OFF_W-1:0]  alloc_off_i,
  input  logic [TAG_W-1:0]  alloc_data_tag_i,
  input  logic [DATA_W-1:0] alloc_data_i,
  output logic              full_o,
  input  logic              cdb_valid_i,
  input  logic [TAG_W-1:0]  cdb_tag_i,
  input  logic [DATA_W-1:0] cdb_data_i,
  output logic              mem_valid_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_data_o,
  input  logic              mem_ready_i
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic             push, pop, empty;
  logic [PTR_W-1:0] head, tail;
  logic [DEPTH-1:0] ent_valid, ent_ready, ent_alloc, ent_free;
  logic [ADDR_W-1:0] ent_addr [DEPTH];
  logic [DATA_W-1:0] ent_data [DEPTH];

  sb_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk_i, .rst_ni,
    .alloc_valid_i,
    .pop_i   (pop),
    .push_o  (push),
    .head_o  (head),
    .tail_o  (tail),
    .full_o,
    .empty_o (empty)
  );

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    assign ent_alloc[i] = push && (tail == PTR_W'(i));
    assign ent_free[i]  = pop  && (head == PTR_W'(i));
    sb_entry #(
      .ADDR_W(ADDR_W), .OFF_W(OFF_W), .DATA_W(DATA_W), .TAG_W(TAG_W)
    ) u_ent (
      .clk_i, .rst_ni,
      .alloc_i          (ent_alloc[i]),
      .alloc_base_tag_i, .alloc_base_i, .alloc_off_i,
      .alloc_data_tag_i, .alloc_data_i,
      .cdb_valid_i, .cdb_tag_i, .cdb_data_i,
      .free_i           (ent_free[i]),
      .valid_o          (ent_valid[i]),
      .ready_o          (ent_ready[i]),
      .addr_o           (ent_addr[i]),
      .data_o           (ent_data[i])
    );
  end

  // only the head may issue: keeps program order
  assign mem_valid_o = ent_valid[head] && ent_ready[head];
  assign mem_addr_o  = ent_addr[head];
  assign mem_data_o  = ent_data[head];
  assign pop         = mem_valid_o && mem_ready_i;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_valid_o && !mem_ready_i) |=> (mem_valid_o && $stable(mem_addr_o) && $stable(mem_data_o))); // R7
  AST_NO_REQ_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty |-> !mem_valid_o); // R6
  AST_ONE_ALLOC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ent_alloc)); // R1
endmodule

// File: tb/tagged_store_buffer_tb.sv
`timescale 1ns/1ps
module tagged_store_buffer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        a_v = 1'b0;
  logic [3:0]  a_bt = '0, a_dt = '0;
  logic [31:0] a_b = '0;
  logic [15:0] a_o = '0;
  logic [63:0] a_d = '0;
  logic        full;
  logic        c_v = 1'b0;
  logic [3:0]  c_t = '0;
  logic [63:0] c_d = '0;
  logic        m_v, m_r = 1'b0;
  logic [31:0] m_a;
  logic [63:0] m_d;
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  tagged_store_buffer dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .alloc_valid_i(a_v), .alloc_base_tag_i(a_bt), .alloc_base_i(a_b),
    .alloc_off_i(a_o), .alloc_data_tag_i(a_dt), .alloc_data_i(a_d),
    .full_o(full),
    .cdb_valid_i(c_v), .cdb_tag_i(c_t), .cdb_data_i(c_d),
    .mem_valid_o(m_v), .mem_addr_o(m_a), .mem_data_o(m_d), .mem_ready_i(m_r)
  );

  typedef struct packed {
    logic [31:0] base;
    logic [15:0] off;
    logic [63:0] data;
    logic [31:0] ea;
  } vec_t;

  localparam vec_t VECS [4] = '{
    '{32'h0000_1000, 16'h0010, 64'h1111_2222_3333_4444, 32'h0000_1010},
    '{32'h0000_2000, 16'hFFF0, 64'hAAAA_BBBB_CCCC_DDDD, 32'h0000_1FF0},
    '{32'hFFFF_FFF8, 16'h0010, 64'h0123_4567_89AB_CDEF, 32'h0000_0008},
    '{32'h8000_0000, 16'h8000, 64'hFEDC_BA98_7654_3210, 32'h7FFF_8000}
  };

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic alloc(input logic [3:0] bt, input logic [31:0] b, input logic [15:0] o,
                       input logic [3:0] dt, input logic [63:0] d);
    a_v = 1'b1; a_bt = bt; a_b = b; a_o = o; a_dt = dt; a_d = d;
    @(negedge clk);
    a_v = 1'b0; a_bt = '0; a_dt = '0;
  endtask

  task automatic bcast(input logic [3:0] t, input logic [63:0] d);
    c_v = 1'b1; c_t = t; c_d = d;
    @(negedge clk);
    c_v = 1'b0; c_t = '0;
  endtask

  task automatic take(input logic [31:0] ea, input logic [63:0] ed, input string req);
    bit got = 0;
    for (int k = 0; k < 20 && !got; k++) begin
      if (m_v) begin
        got = 1;
        check(m_a == ea, req, 64'(m_a), 64'(ea));
        check(m_d == ed, req, m_d, ed);
        m_r = 1'b1;
        @(negedge clk);
        m_r = 1'b0;
      end else begin
        @(negedge clk);
      end
    end
    if (!got) check(1'b0, req, 64'(0), 64'(1));
  endtask

  task automatic idle(input int n, input string req);
    for (int k = 0; k < n; k++) begin
      check(!m_v, req, 64'(m_v), 64'(0));
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(!m_v, "R8", 64'(m_v), 64'(0));
    check(!full, "R8", 64'(full), 64'(0));
    rst_n = 1'b1;
    @(negedge clk);

    // R2 / R1: fill from table, probe overflow, drain in order
    for (int i = 0; i < 4; i++) alloc(4'd0, VECS[i].base, VECS[i].off, 4'd0, VECS[i].data);
    check(full, "R1", 64'(full), 64'(1));
    alloc(4'd0, 32'h0000_5000, 16'h0000, 4'd0, 64'hDEAD_DEAD_DEAD_DEAD);
    for (int i = 0; i < 4; i++) begin
      take(VECS[i].ea, VECS[i].data, "R2");
      if (i == 0) check(!full, "R1", 64'(full), 64'(0));
    end
    idle(3, "R1");

    // R3: pending base
    alloc(4'd5, 32'h0, 16'h0020, 4'd0, 64'h5555_0000_0000_5555);
    idle(3, "R3");
    bcast(4'd5, 64'hFFFF_FFFF_0000_1000);
    take(32'h0000_1020, 64'h5555_0000_0000_5555, "R3");

    // R4: pending data, foreign tag ignored
    alloc(4'd0, 32'h0000_3000, 16'h0004, 4'd7, 64'h0);
    bcast(4'd3, 64'h3333_3333_3333_3333);
    idle(3, "R4");
    bcast(4'd7, 64'h7777_0000_7777_0000);
    take(32'h0000_3004, 64'h7777_0000_7777_0000, "R4");

    // R5: broadcast in allocation cycle
    c_v = 1'b1; c_t = 4'd9; c_d = 64'h9999_9999_0000_0009;
    alloc(4'd0, 32'h0000_4000, 16'h0000, 4'd9, 64'h0);
    c_v = 1'b0; c_t = '0;
    take(32'h0000_4000, 64'h9999_9999_0000_0009, "R5");

    // R6: younger ready store waits behind older pending one
    alloc(4'd0, 32'h0000_6000, 16'h0000, 4'd2, 64'h0);
    alloc(4'd0, 32'h0000_6100, 16'h0000, 4'd0, 64'hBBBB_0000_0000_BBBB);
    idle(4, "R6");
    bcast(4'd2, 64'hAAAA_0000_0000_AAAA);
    take(32'h0000_6000, 64'hAAAA_0000_0000_AAAA, "R6");
    take(32'h0000_6100, 64'hBBBB_0000_0000_BBBB, "R6");

    // R7: back-pressure then single acceptance
    alloc(4'd0, 32'h0000_7000, 16'h0008, 4'd0, 64'h7070_7070_7070_7070);
    repeat (2) @(negedge clk);
    check(m_v, "R7", 64'(m_v), 64'(1));
    repeat (3) @(negedge clk);
    check(m_v && m_a == 32'h0000_7008, "R7", 64'(m_a), 64'(32'h0000_7008));
    check(m_d == 64'h7070_7070_7070_7070, "R7", m_d, 64'h7070_7070_7070_7070);
    m_r = 1'b1;
    @(negedge clk);
    m_r = 1'b0;
    idle(2, "R7");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule